// File: doc/BRIEF.md
# Packed Vector Shifter with Shared Count

This block shifts a 128-bit vector as a set of equal-width lanes: eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Every lane moves by the same distance. That distance is the unsigned 64-bit value held in the lower half of a second 128-bit operand. The upper half of that operand plays no part.

Three operations are offered: logical left, logical right and arithmetic right. The arithmetic right shift applies only to 16- and 32-bit lanes. A count that reaches or passes the lane width does not wrap. A logical shift then clears the lane, and an arithmetic shift fills the lane with copies of its sign bit. Any combination that the block does not support raises an error flag and returns an all-zero vector.

The result is registered. A request presented with `in_valid` produces `out_valid` one clock later.

Top module: `simd_lane_shifter`

## Requirements
- R1: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R2: Operation code 2'b00 is a logical left shift. Lane-size code 2'b00 selects 16-bit lanes, 2'b01 selects 32-bit lanes and 2'b10 selects 64-bit lanes. Lane k occupies bits [k*W+W-1 : k*W]. Zeros enter from the low end of each lane.
- R3: Operation code 2'b01 is a logical right shift. Zeros enter from the high end of each lane.
- R4: Operation code 2'b10 is an arithmetic right shift for 16- and 32-bit lanes. Copies of the lane's top bit enter from the high end.
- R5: The shift distance is the unsigned value of `in_count[63:0]`. Bits `in_count[127:64]` have no effect on the result.
- R6: For a logical shift, a distance of the lane width or more gives an all-zero lane. This includes distances with any bit set above bit 6.
- R7: For an arithmetic shift, a distance of the lane width or more sets every bit of the lane to its sign bit.
- R8: The block flags three combinations as illegal: operation 2'b10 with 64-bit lanes, operation code 2'b11, and lane-size code 2'b11. An illegal request gives `out_err`=1 and `out_data`=0. A legal request gives `out_err`=0.
- R9: `out_data` and `out_err` keep their values in any cycle where `in_valid` is low.
- R10: While reset is held, `out_valid`, `out_err` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 128 | Vector to be shifted |
| in_count | input | 128 | Count operand; only bits 63:0 are used |
| in_op | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right |
| in_lane | input | 2 | Lane size: 00 16-bit, 01 32-bit, 10 64-bit |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 128 | Shifted vector |
| out_err | output | 1 | Illegal request flag |

## Verification
A request is accepted at the first rising edge while `in_valid` is high. The result, the error flag and `out_valid` are all set at that same edge. Every result is therefore due exactly one cycle after its request. The bench drives inputs on the falling edge, waits one full clock, and samples outputs on the next falling edge, well away from the capturing edge. For the hold check, the bench drops `in_valid`, changes the operands and samples again one cycle later to confirm nothing moved.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_RSV = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    LW_16  = 2'b00,
    LW_32  = 2'b01,
    LW_64  = 2'b10,
    LW_RSV = 2'b11
  } lane_sel_e;
endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode #(
  parameter int CNT_W = 64,
  parameter int AMT_W = 7
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [AMT_W-1:0] amt,
  output logic             hi_nz
);
  // Low bits feed the shifters; any set bit above them marks the count oversized.
  assign amt   = cnt[AMT_W-1:0];
  assign hi_nz = |cnt[CNT_W-1:AMT_W];
endmodule

// File: rtl/shift_lane_array.sv
module shift_lane_array
  import shift_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16,
  parameter int AMT_W  = 7
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [AMT_W-1:0] amt,
  input  logic             hi_nz,
  input  logic [1:0]       op,
  output logic [VEC_W-1:0] res
);
  localparam int NL   = VEC_W / LANE_W;
  localparam int SH_W = $clog2(LANE_W);

  logic            over;
  logic [SH_W-1:0] sh;

  assign over = hi_nz || (amt >= AMT_W'(LANE_W));
  assign sh   = amt[SH_W-1:0];

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [LANE_W-1:0] d;
    logic [LANE_W-1:0] r;
    assign d = vec[k*LANE_W +: LANE_W];
    always_comb begin
      r = '0;
      case (op)
        OP_SLL:  r = over ? '0 : (d << sh);
        OP_SRL:  r = over ? '0 : (d >> sh);
        OP_SRA:  r = over ? {LANE_W{d[LANE_W-1]}}
                          : LANE_W'($signed(d) >>> sh);
        default: r = '0;
      endcase
    end
    assign res[k*LANE_W +: LANE_W] = r;
  end
endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
  import shift_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int CNT_W      = 64,
  parameter int MIN_LANE_W = 16,
  parameter int NUM_SIZES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_count,
  input  logic [1:0]       in_op,
  input  logic [1:0]       in_lane,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data,
  output logic             out_err
);
  localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);
  localparam int AMT_W      = $clog2(MAX_LANE_W) + 1;

  logic [AMT_W-1:0] amt;
  logic             hi_nz;
  logic [VEC_W-1:0] res_w [NUM_SIZES];
  logic             illegal;
  logic [VEC_W-1:0] nxt_data;
  logic             nxt_err;

  shift_count_decode #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_dec (
    .cnt   (in_count[CNT_W-1:0]),
    .amt   (amt),
    .hi_nz (hi_nz)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    shift_lane_array #(
      .VEC_W  (VEC_W),
      .LANE_W (MIN_LANE_W << g),
      .AMT_W  (AMT_W)
    ) u_arr (
      .vec   (in_data),
      .amt   (amt),
      .hi_nz (hi_nz),
      .op    (in_op),
      .res   (res_w[g])
    );
  end

  // Next-state logic
  always_comb begin
    illegal = (in_op == OP_RSV) || (in_lane == LW_RSV) ||
              ((in_op == OP_SRA) && (in_lane == LW_64));
    nxt_err = illegal;
    case (in_lane)
      LW_16:   nxt_data = res_w[0];
      LW_32:   nxt_data = res_w[1];
      LW_64:   nxt_data = res_w[2];
      default: nxt_data = '0;
    endcase
    if (illegal) nxt_data = '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_err  <= nxt_err;
      end
    end
  end
endmodule

// File: rtl/simd_shift_chk.sv
module simd_shift_chk #(
  parameter int VEC_W = 128,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] in_data,
  input logic [VEC_W-1:0] in_count,
  input logic [1:0]       in_op,
  input logic [1:0]       in_lane,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data,
  input logic             out_err
);
  localparam int BIG_LSB = 6;

  logic legal_logical;
  assign legal_logical = (in_op == 2'b00 || in_op == 2'b01) && (in_lane != 2'b11);

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_big_count_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal_logical && (|in_count[CNT_W-1:BIG_LSB])) |=> (out_data == '0));
  p_illegal_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 2'b11 || in_lane == 2'b11 || (in_op == 2'b10 && in_lane == 2'b10)))
      |=> (out_err && out_data == '0));
  p_legal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 2'b11 && in_lane != 2'b11 && !(in_op == 2'b10 && in_lane == 2'b10))
      |=> !out_err);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_err)));

  always_comb begin
    if (!rst_n) begin
      a_reset_r10: assert (!out_valid && !out_err && out_data == '0);
    end
  end
endmodule

bind simd_lane_shifter simd_shift_chk #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_count  (in_count),
  .in_op     (in_op),
  .in_lane   (in_lane),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/simd_lane_shifter_tb.sv
`timescale 1ns/1ps
module simd_lane_shifter_tb;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic [127:0] in_count;
  logic [1:0]   in_op;
  logic [1:0]   in_lane;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  simd_lane_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_op(in_op), .in_lane(in_lane),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference built from the requirement text, bit by bit
  function automatic logic [127:0] ref_shift(input logic [127:0] d, input logic [127:0] c,
                                             input logic [1:0] op, input logic [1:0] lw);
    logic [127:0] r;
    logic [63:0]  s;
    int w;
    r = '0;
    s = c[63:0];
    w = 16 << lw;
    if (op == 2'b11 || lw == 2'b11 || (op == 2'b10 && lw == 2'b10)) return '0;
    for (int k = 0; k < 128 / w; k++) begin
      for (int b = 0; b < w; b++) begin
        logic sign;
        sign = d[k*w + w - 1];
        if (op == 2'b00)
          r[k*w + b] = (s < 64'(w) && 64'(b) >= s) ? d[k*w + b - int'(s)] : 1'b0;
        else if (s < 64'(w) && 64'(b) + s < 64'(w))
          r[k*w + b] = d[k*w + b + int'(s)];
        else
          r[k*w + b] = (op == 2'b10) ? sign : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic run_one(input string tag, input logic [127:0] d, input logic [127:0] c,
                         input logic [1:0] op, input logic [1:0] lw);
    logic exp_err;
    exp_err = (op == 2'b11 || lw == 2'b11 || (op == 2'b10 && lw == 2'b10));
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_count = c; in_op = op; in_lane = lw;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 valid"}, 128'(out_valid), 128'(1));
    chk({tag, " data"}, out_data, ref_shift(d, c, op, lw));
    chk({tag, " R8 err"}, 128'(out_err), 128'(exp_err));
  endtask

  task automatic t_reset;
    chk("R10 reset valid", 128'(out_valid), 128'(0));
    chk("R10 reset data", out_data, '0);
    chk("R10 reset err", 128'(out_err), 128'(0));
  endtask

  task automatic t_basic;
    logic [127:0] pat;
    pat = 128'h8001_7F3C_1234_FFFF_0F0F_A5A5_C000_0003;
    run_one("R2 sll16 by 3", pat, 128'd3, 2'b00, 2'b00);
    run_one("R2 sll64 by 40", pat, 128'd40, 2'b00, 2'b10);
    run_one("R3 srl32 by 7", pat, 128'd7, 2'b01, 2'b01);
    run_one("R3 srl64 by 63", pat, 128'd63, 2'b01, 2'b10);
    run_one("R4 sra16 by 5", pat, 128'd5, 2'b10, 2'b00);
    run_one("R4 sra32 by 31", pat, 128'd31, 2'b10, 2'b01);
  endtask

  task automatic t_count_edges;
    logic [127:0] pat;
    pat = 128'hF00D_8765_4321_ABCD_8000_7FFF_0123_89AB;
    run_one("R5 upper count half ignored", pat, {64'hFFFF_FFFF_FFFF_FFFF, 64'd4}, 2'b01, 2'b00);
    run_one("R6 sll16 count 15", pat, 128'd15, 2'b00, 2'b00);
    run_one("R6 sll16 count 16", pat, 128'd16, 2'b00, 2'b00);
    run_one("R6 srl32 count bit40", pat, {64'd0, 64'h0000_0100_0000_0001}, 2'b01, 2'b01);
    run_one("R6 srl64 count 64", pat, 128'd64, 2'b01, 2'b10);
    run_one("R7 sra16 count 16", pat, 128'd16, 2'b10, 2'b00);
    run_one("R7 sra32 huge count", pat, {64'd0, 64'h8000_0000_0000_0000}, 2'b10, 2'b01);
  endtask

  task automatic t_illegal;
    logic [127:0] pat;
    pat = 128'hFFFF_0000_1111_2222_3333_4444_5555_6666;
    run_one("R8 sra64 illegal", pat, 128'd1, 2'b10, 2'b10);
    run_one("R8 op 11 illegal", pat, 128'd1, 2'b11, 2'b00);
    run_one("R8 lane 11 illegal", pat, 128'd1, 2'b00, 2'b11);
  endtask

  task automatic t_hold;
    logic [127:0] pat;
    logic [127:0] exp;
    pat = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
    exp = ref_shift(pat, 128'd8, 2'b00, 2'b01);
    run_one("R9 prime", pat, 128'd8, 2'b00, 2'b01);
    @(negedge clk);
    in_valid = 1'b0; in_data = ~pat; in_count = 128'd100; in_op = 2'b11; in_lane = 2'b11;
    @(negedge clk);
    chk("R1 valid low when idle", 128'(out_valid), 128'(0));
    chk("R9 data held", out_data, exp);
    chk("R9 err held", 128'(out_err), 128'(0));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_count = '0; in_op = '0; in_lane = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_count_edges();
    t_illegal();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule